// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block paces a single read or write on an external asynchronous memory bus. A request launches one access that passes through three phases in a fixed order: lead, active and trail. The length of each phase comes from a 32-bit timing word that the caller supplies for the selected zone. The word holds separate lead, active and trail fields for reads and for writes. One bit in the word doubles every count. Another bit lets an external ready line hold the active phase open for as long as needed. A further bit chooses whether that ready line is sampled as it arrives or first passes through a synchronizer.

The block produces one indicator per phase and a read strobe enable and a write strobe enable, both limited to the active phase. It also produces a one-cycle done pulse and a busy level. A configuration error flag is raised when the timing word breaks its usage rules. The access still runs in that case, with the lead clamped to a legal minimum. Address decode, data muxing, zone choice, clock division and arbitration all sit outside the block.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every output (phase indicators, strobes, done, busy, error) is low.
- R2: A request sampled high while the block is idle starts an access, and the lead indicator is high in the next cycle. A request sampled while busy is ignored and starts no second access.
- R3: The phases run lead, then active, then trail, with at most one indicator high at a time. Writes (write select 1) take lead from bits 6:5, active from bits 4:2 and trail from bits 1:0. Reads take lead from bits 13:12, active from bits 11:9 and trail from bits 8:7. The lead lasts the field value in cycles and the trail lasts the field value in cycles.
- R4: The active phase lasts at least 1 plus its (scaled) active field value in cycles.
- R5: When bit 22 is 1, the lead, active-field and trail counts are all doubled before use. When bit 22 is 0, they are used unchanged.
- R6: With a trail count of 0, the access ends right after the active phase.
- R7: The read strobe enable is high in exactly the active cycles of a read, and the write strobe enable in exactly the active cycles of a write. Neither is high at any other time.
- R8: Done is high for exactly one cycle, in the cycle right after the last phase cycle, with all phase indicators low.
- R9: When bit 14 is 0, the ready input is ignored. The active phase ends after its programmed length even with ready held low.
- R10: When bit 14 is 1 and bit 15 is 0, ready is used directly. The active phase ends at the first clock edge where the minimum has elapsed and ready is high.
- R11: When bits 14 and 15 are both 1, ready passes through a two-flop synchronizer. A ready that rises in active cycle D therefore ends the phase no earlier than after cycle D+2.
- R12: The error flag is set for an access whose lead field is 0, or whose active field is 0 while bit 14 is 1, or whose bits 17:16 are not 1,1. It appears with the lead indicator and holds until the next access is accepted. A lead field of 0 is run as 1 (scaled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start an access (taken only when idle) |
| wr_i | input | 1 | 1 selects write timing, 0 selects read timing |
| timing_i | input | 32 | Per-zone timing word, captured when the access starts |
| ready_i | input | 1 | External ready, high when the device may finish |
| lead_o | output | 1 | Lead phase indicator |
| active_o | output | 1 | Active phase indicator |
| trail_o | output | 1 | Trail phase indicator |
| rd_strobe_o | output | 1 | Read strobe enable |
| wr_strobe_o | output | 1 | Write strobe enable |
| done_o | output | 1 | One-cycle pulse after the access ends |
| busy_o | output | 1 | High while an access is in progress |
| cfg_err_o | output | 1 | Timing word of the last accepted access broke a usage rule |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and 4-bit phase counters. These defaults reach the longest legal phase, a doubled active of 15 cycles, and the full synchronizer delay seen in asynchronous ready mode. Random timing words cover all field values, both scaling settings, all ready modes and illegal fixed bits. Each comes with a random ready release cycle, so the ready release falls both before and after the programmed minimum. Directed accesses cover the reset-default word, the shortest possible access and each error cause.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 4;

  localparam int WR_TRAIL_LSB  = 0;
  localparam int WR_ACT_LSB    = 2;
  localparam int WR_LEAD_LSB   = 5;
  localparam int RD_TRAIL_LSB  = 7;
  localparam int RD_ACT_LSB    = 9;
  localparam int RD_LEAD_LSB   = 12;
  localparam int RDY_EN_BIT    = 14;
  localparam int RDY_ASYNC_BIT = 15;
  localparam int FIXED_LSB     = 16;
  localparam int SCALE_BIT     = 22;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] lead;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] trail;
    logic             use_rdy;
    logic             rdy_async;
    logic             wr;
    logic             err;
  } access_cfg_t;

endpackage

// File: rtl/xbus_cfg_decode.sv
module xbus_cfg_decode
  import xbus_seq_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             wr_i,
  output access_cfg_t      acc_o
);

  logic [1:0]       lead_f, trail_f, lead_c;
  logic [2:0]       act_f;
  logic             scale;
  logic [CNT_W-1:0] lead_w, act_w, trail_w;
  logic             unused_bits;

  assign unused_bits = ^{cfg_i[CFG_W-1:SCALE_BIT+1], cfg_i[SCALE_BIT-1:FIXED_LSB+2]};

  always_comb begin
    if (wr_i) begin
      lead_f  = cfg_i[WR_LEAD_LSB +: 2];
      act_f   = cfg_i[WR_ACT_LSB +: 3];
      trail_f = cfg_i[WR_TRAIL_LSB +: 2];
    end else begin
      lead_f  = cfg_i[RD_LEAD_LSB +: 2];
      act_f   = cfg_i[RD_ACT_LSB +: 3];
      trail_f = cfg_i[RD_TRAIL_LSB +: 2];
    end
    scale  = cfg_i[SCALE_BIT];
    lead_c = (lead_f == 2'd0) ? 2'd1 : lead_f;

    lead_w  = {{(CNT_W-2){1'b0}}, lead_c};
    act_w   = {{(CNT_W-3){1'b0}}, act_f};
    trail_w = {{(CNT_W-2){1'b0}}, trail_f};
    if (scale) begin
      lead_w  = lead_w << 1;
      act_w   = act_w << 1;
      trail_w = trail_w << 1;
    end

    acc_o.lead      = lead_w;
    acc_o.act       = act_w + {{(CNT_W-1){1'b0}}, 1'b1};
    acc_o.trail     = trail_w;
    acc_o.use_rdy   = cfg_i[RDY_EN_BIT];
    acc_o.rdy_async = cfg_i[RDY_ASYNC_BIT];
    acc_o.wr        = wr_i;
    acc_o.err       = (lead_f == 2'd0)
                    | (cfg_i[RDY_EN_BIT] & (act_f == 3'd0))
                    | (cfg_i[FIXED_LSB +: 2] != 2'b11);

    a_r12_lead_clamped: assert (acc_o.lead != '0);
    a_r4_active_min: assert (acc_o.act != '0);
  end

endmodule

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
  import xbus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_i,
  input  access_cfg_t acc_i,
  input  logic        rdy_raw_i,
  input  logic        rdy_sync_i,
  output logic        lead_o,
  output logic        active_o,
  output logic        trail_o,
  output logic        rd_strobe_o,
  output logic        wr_strobe_o,
  output logic        done_o,
  output logic        busy_o,
  output logic        cfg_err_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  access_cfg_t      cur_q;
  logic             done_d, accept, rdy_ok;

  assign accept = (st_q == PH_IDLE) && req_i;
  assign rdy_ok = !cur_q.use_rdy || (cur_q.rdy_async ? rdy_sync_i : rdy_raw_i);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      PH_IDLE: begin
        if (req_i) begin
          st_d  = PH_LEAD;
          cnt_d = acc_i.lead - ONE;
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          st_d  = PH_ACTIVE;
          cnt_d = cur_q.act - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - ONE;
        end else if (rdy_ok) begin
          if (cur_q.trail == '0) begin
            st_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            st_d  = PH_TRAIL;
            cnt_d = cur_q.trail - ONE;
          end
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PH_IDLE;
      cnt_q       <= '0;
      cur_q       <= '0;
      lead_o      <= 1'b0;
      active_o    <= 1'b0;
      trail_o     <= 1'b0;
      rd_strobe_o <= 1'b0;
      wr_strobe_o <= 1'b0;
      done_o      <= 1'b0;
      busy_o      <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      if (accept) begin
        cur_q     <= acc_i;
        cfg_err_o <= acc_i.err;
      end
      lead_o      <= (st_d == PH_LEAD);
      active_o    <= (st_d == PH_ACTIVE);
      trail_o     <= (st_d == PH_TRAIL);
      rd_strobe_o <= (st_d == PH_ACTIVE) && !cur_q.wr;
      wr_strobe_o <= (st_d == PH_ACTIVE) && cur_q.wr;
      done_o      <= done_d;
      busy_o      <= (st_d != PH_IDLE);
    end
  end

  a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_o, active_o, trail_o}));

  a_r7_strobe_in_active: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o || wr_strobe_o) |-> (active_o && !(rd_strobe_o && wr_strobe_o)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_after_phase: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(active_o || trail_o) && !busy_o));

  a_r2_lead_from_idle_req: assert property (@(posedge clk) disable iff (rst)
    $rose(lead_o) |-> ($past(req_i) && !$past(busy_o)));

  a_r4_active_held: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_ACTIVE && cnt_q != '0) |=> active_o);

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] timing_i,
  input  logic             ready_i,
  output logic             lead_o,
  output logic             active_o,
  output logic             trail_o,
  output logic             rd_strobe_o,
  output logic             wr_strobe_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             cfg_err_o
);

  access_cfg_t acc;
  logic        rdy_sync;

  xbus_cfg_decode u_decode (
    .cfg_i (timing_i),
    .wr_i  (wr_i),
    .acc_o (acc)
  );

  xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ready_i),
    .q_o (rdy_sync)
  );

  xbus_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .acc_i       (acc),
    .rdy_raw_i   (ready_i),
    .rdy_sync_i  (rdy_sync),
    .lead_o      (lead_o),
    .active_o    (active_o),
    .trail_o     (trail_o),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .cfg_err_o   (cfg_err_o)
  );

endmodule

// File: tb/xbus_cycle_seq_tb.sv
module xbus_cycle_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] timing_i = '0;
  logic        ready_i = 1'b0;
  logic lead_o, active_o, trail_o, rd_strobe_o, wr_strobe_o, done_o, busy_o, cfg_err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cycle_seq u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i), .timing_i(timing_i),
    .ready_i(ready_i), .lead_o(lead_o), .active_o(active_o), .trail_o(trail_o),
    .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o), .done_o(done_o),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int wt, input int wa, input int wl,
                                         input int rt, input int ra, input int rl,
                                         input bit ue, input bit ua, input int fx,
                                         input bit sc);
    logic [31:0] c;
    c = '0;
    c[1:0] = 2'(wt);  c[4:2] = 3'(wa);  c[6:5] = 2'(wl);
    c[8:7] = 2'(rt);  c[11:9] = 3'(ra); c[13:12] = 2'(rl);
    c[14] = ue; c[15] = ua; c[17:16] = 2'(fx); c[22] = sc;
    return c;
  endfunction

  function automatic int exp_lead(input logic [31:0] c, input bit wr);
    int f = wr ? int'(c[6:5]) : int'(c[13:12]);
    if (f == 0) f = 1;
    return c[22] ? 2*f : f;
  endfunction

  function automatic int exp_act(input logic [31:0] c, input bit wr, input int d);
    int f = wr ? int'(c[4:2]) : int'(c[11:9]);
    int a = (c[22] ? 2*f : f) + 1;
    int r;
    if (c[14]) begin
      r = c[15] ? d + 2 : d;
      if (r > a) a = r;
    end
    return a;
  endfunction

  function automatic int exp_trail(input logic [31:0] c, input bit wr);
    int f = wr ? int'(c[1:0]) : int'(c[8:7]);
    return c[22] ? 2*f : f;
  endfunction

  function automatic bit exp_err(input logic [31:0] c, input bit wr);
    int l = wr ? int'(c[6:5]) : int'(c[13:12]);
    int a = wr ? int'(c[4:2]) : int'(c[11:9]);
    return (l == 0) || (c[14] && a == 0) || (c[17:16] != 2'b11);
  endfunction

  // d: active cycle in which ready is raised (0 = never)
  task automatic run_access(input logic [31:0] c, input bit wr, input int d);
    int nl = 0, na = 0, nt = 0, idx = 0, done_idx = 0, strobe_bad = 0, extra = 0;
    bit seen_a = 0, seen_t = 0, order_bad = 0;
    int el = exp_lead(c, wr);
    int ea = exp_act(c, wr, d);
    int et = exp_trail(c, wr);
    string atag;
    atag = !c[14] ? "R9" : (c[15] ? "R11" : "R10");
    @(negedge clk);
    timing_i = c; wr_i = wr; ready_i = 1'b0;
    repeat (3) @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(cfg_err_o == exp_err(c, wr), "R12 error flag", cfg_err_o, exp_err(c, wr));
    while (idx < 100) begin
      idx++;
      if (done_o) begin
        done_idx = idx;
        chk(!(lead_o || active_o || trail_o), "R8 phases low with done", 1, 0);
        break;
      end
      if (lead_o) begin nl++; if (seen_a || seen_t) order_bad = 1; end
      if (active_o) begin na++; seen_a = 1; if (seen_t) order_bad = 1; end
      if (trail_o) begin nt++; seen_t = 1; end
      if (rd_strobe_o != (active_o && !wr)) strobe_bad++;
      if (wr_strobe_o != (active_o && wr)) strobe_bad++;
      if (active_o && c[14] && d != 0 && na == d) ready_i = 1'b1;
      req_i = (idx == 2);
      @(negedge clk);
    end
    req_i = 1'b0;
    chk(nl == el, "R3/R5 lead length", nl, el);
    chk(na == ea, {atag, " R4 active length"}, na, ea);
    chk(nt == et, "R3/R6 trail length", nt, et);
    chk(done_idx == el + ea + et + 1, "R8 done cycle", done_idx, el + ea + et + 1);
    chk(!order_bad, "R3 phase order", order_bad, 0);
    chk(strobe_bad == 0, "R7 strobes", strobe_bad, 0);
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    repeat (3) begin
      if (busy_o || lead_o) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R2 request while busy ignored", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({lead_o, active_o, trail_o, rd_strobe_o, wr_strobe_o, done_o, busy_o, cfg_err_o} == 8'd0,
        "R1 outputs in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({lead_o, active_o, trail_o, rd_strobe_o, wr_strobe_o, done_o, busy_o, cfg_err_o} == 8'd0,
        "R1 outputs after reset", 1, 0);

    // reset-default word: all fields max, ready on, async, doubled
    run_access(32'h0043_FFFF, 1'b0, 3);
    run_access(32'h0043_FFFF, 1'b1, 20);
    // shortest access, R6 trail 0, R5 unscaled, R9 ready ignored
    run_access(mk_cfg(0, 0, 1, 0, 0, 1, 0, 0, 3, 0), 1'b0, 0);
    run_access(mk_cfg(0, 0, 1, 0, 0, 1, 0, 0, 3, 0), 1'b1, 0);
    // R12 lead field 0
    run_access(mk_cfg(2, 3, 0, 1, 2, 0, 0, 0, 3, 1), 1'b1, 0);
    // R12 active 0 with ready, R10 sync ready
    run_access(mk_cfg(1, 0, 2, 1, 0, 2, 1, 0, 3, 0), 1'b0, 5);
    // R12 fixed bits wrong
    run_access(mk_cfg(1, 1, 1, 1, 1, 1, 0, 0, 1, 0), 1'b0, 0);
    // R11 ready before minimum elapses
    run_access(mk_cfg(3, 7, 3, 3, 7, 3, 1, 1, 3, 1), 1'b1, 1);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] c;
      bit ue = 1'($urandom_range(0, 1));
      int fx = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 2)) : 3;
      c = mk_cfg($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3),
                 ue, 1'($urandom_range(0, 1)), fx, 1'($urandom_range(0, 1)));
      run_access(c, 1'($urandom_range(0, 1)), ue ? int'($urandom_range(1, 20)) : 0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule